// File: doc/BRIEF.md
# Post-Scale Clock Divider

This block turns a fast source clock into one slower output clock. The high phase and the low phase each have their own length, counted in source cycles. A start-up delay holds the output low after reset before its first rising edge. The delay is the initial count plus a phase-tap offset of zero to seven source cycles. An instance with different offsets can therefore place several outputs at fixed phases from the same source.

There are three output modes. Even mode gives exact whole-cycle high and low phases. Odd mode stretches each high phase by half a source cycle, using a falling-edge retimed copy, so an odd total division can reach 50 percent duty. Bypass mode passes the source clock straight through.

An enable input gates the output. In divider modes it is sampled only where a high phase would begin, so high phases are always whole. The phase counter keeps running while the output is gated. In bypass mode the enable is captured on the falling source edge, so no pulse is ever cut short.

Top module: `postscale_div`

## Requirements
- R1: While `rst_ni` is low the output is low in every mode, and the sequencer restarts its start-up delay when reset is released.
- R2: Each count field is a 9-bit value N. Values 1 to 511 mean N source cycles, and 0 means 512 source cycles.
- R3: After reset is released the divider output stays low for D = init + tap source cycles. Its first high phase starts on the D-th rising source edge.
- R4: Even mode (`mode_i` = 2'b01): the output is high for exactly `high_cnt_i` source cycles, then low for exactly `low_cnt_i` source cycles, and this repeats.
- R5: Odd mode (`mode_i` = 2'b10): each high phase is stretched by half a source cycle and ends on a falling source edge. The following low phase is shortened by the same half cycle.
- R6: Bypass mode (`mode_i` = 2'b00, and also 2'b11): the output equals the source clock ANDed with `en_i` as captured on the previous falling source edge.
- R7: In the divider modes `en_i` is sampled only on the rising edge that starts a period. A change at any other time has no effect on the output until the next period starts, so a high phase is never cut short.
- R8: While the sampled enable is low the output stays low for whole periods. The period counter keeps running, so re-enabling resumes on the original period grid.
- R9: The phase-tap field (`tap_i`, 0 to 7) adds its value in source cycles to the start-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable |
| mode_i | input | 2 | 00 bypass, 01 even, 10 odd, 11 bypass |
| high_cnt_i | input | 9 | High-phase length in source cycles (0 means 512) |
| low_cnt_i | input | 9 | Low-phase length in source cycles (0 means 512) |
| init_cnt_i | input | 9 | Start-up delay in source cycles (0 means 512) |
| tap_i | input | 3 | Phase-tap offset added to the start-up delay |
| clk_o | output | 1 | Divided or bypassed output clock |

## Verification
The assertions assume that mode and count fields stay constant between resets. Their phase-length and first-edge checks compare against the live fields, so a change in mid-run would be outside their scope. The stimulus therefore changes configuration only while reset is held. The enable input is the one input moved during operation. It is driven away from both clock edges, and it toggles with periods that do not line up with the division ratio, so that it changes inside high phases, inside low phases and at period starts.

// File: rtl/postscale_div_pkg.sv
`timescale 1ns/1ps
package postscale_div_pkg;

  typedef enum logic [1:0] {
    DM_BYPASS = 2'b00,
    DM_EVEN   = 2'b01,
    DM_ODD    = 2'b10,
    DM_BYP_X  = 2'b11
  } div_mode_e;

  typedef enum logic [1:0] {
    ST_DELAY = 2'b00,
    ST_HIGH  = 2'b01,
    ST_LOW   = 2'b10
  } div_state_e;

endpackage

// File: rtl/postscale_div_cfg.sv
`timescale 1ns/1ps
module postscale_div_cfg #(
  parameter int CNT_W = 9,
  parameter int TAP_W = 3,
  localparam int LEN_W = CNT_W + 1,
  localparam int DLY_W = CNT_W + 2
) (
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [LEN_W-1:0] h_len_o,
  output logic [LEN_W-1:0] l_len_o,
  output logic [DLY_W-1:0] d_len_o
);

  // field value zero selects the full 2**CNT_W length
  function automatic logic [LEN_W-1:0] decode_len(input logic [CNT_W-1:0] f);
    decode_len = (f == '0) ? (LEN_W'(1) << CNT_W) : LEN_W'(f);
  endfunction

  logic [LEN_W-1:0] init_len;

  assign h_len_o  = decode_len(high_cnt_i);
  assign l_len_o  = decode_len(low_cnt_i);
  assign init_len = decode_len(init_cnt_i);
  assign d_len_o  = DLY_W'(init_len) + DLY_W'(tap_i);

endmodule

// File: rtl/postscale_div_seq.sv
`timescale 1ns/1ps
module postscale_div_seq
  import postscale_div_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int DLY_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] h_len_i,
  input  logic [LEN_W-1:0] l_len_i,
  input  logic [DLY_W-1:0] d_len_i,
  output logic             hi_o
);

  div_state_e       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             start;
  logic             en_q, en_d;
  logic             hi_q, hi_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + DLY_W'(1);
    start = 1'b0;
    unique case (st_q)
      ST_DELAY: if (cnt_q == d_len_i - DLY_W'(1)) begin
        st_d  = ST_HIGH;
        cnt_d = '0;
        start = 1'b1;
      end
      ST_HIGH: if (cnt_q == DLY_W'(h_len_i) - DLY_W'(1)) begin
        st_d  = ST_LOW;
        cnt_d = '0;
      end
      ST_LOW: if (cnt_q == DLY_W'(l_len_i) - DLY_W'(1)) begin
        st_d  = ST_HIGH;
        cnt_d = '0;
        start = 1'b1;
      end
      default: begin
        st_d  = ST_DELAY;
        cnt_d = '0;
      end
    endcase
    // enable only takes effect at a period start: whole high phases only
    en_d = start ? en_i : en_q;
    hi_d = (st_d == ST_HIGH) && en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_DELAY;
      cnt_q <= '0;
      en_q  <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      en_q  <= en_d;
      hi_q  <= hi_d;
    end
  end

  assign hi_o = hi_q;

  // checker state
  logic [DLY_W-1:0] run_q, since_q;
  logic             started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      since_q   <= '0;
      started_q <= 1'b0;
    end else begin
      run_q <= hi_q ? run_q + DLY_W'(1) : '0;
      if (!started_q) since_q <= since_q + DLY_W'(1);
      if (start) started_q <= 1'b1;
    end
  end

  p_first_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !started_q) |-> (since_q == d_len_i - DLY_W'(1)));

  p_high_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_q) |-> (run_q == DLY_W'(h_len_i)));

  p_gate_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> !$past(hi_q));

endmodule

// File: rtl/postscale_div_out.sv
`timescale 1ns/1ps
module postscale_div_out
  import postscale_div_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  div_mode_e mode_i,
  input  logic      hi_i,
  output logic      clk_o
);

  logic ext_q;
  logic byp_en_q;

  // falling-edge copies: half-cycle stretch and glitch-free bypass gate
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q    <= 1'b0;
      byp_en_q <= 1'b0;
    end else begin
      ext_q    <= hi_i;
      byp_en_q <= en_i;
    end
  end

  always_comb begin
    unique case (mode_i)
      DM_EVEN: clk_o = hi_i;
      DM_ODD:  clk_o = hi_i | ext_q;
      default: clk_o = clk_i & byp_en_q;
    endcase
  end

  p_ext_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q == hi_i);

endmodule

// File: rtl/postscale_div.sv
`timescale 1ns/1ps
module postscale_div
  import postscale_div_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int TAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             clk_o
);

  localparam int LEN_W = CNT_W + 1;
  localparam int DLY_W = CNT_W + 2;

  logic [LEN_W-1:0] h_len, l_len;
  logic [DLY_W-1:0] d_len;
  logic             hi;

  postscale_div_cfg #(
    .CNT_W(CNT_W),
    .TAP_W(TAP_W)
  ) u_cfg (
    .high_cnt_i(high_cnt_i),
    .low_cnt_i (low_cnt_i),
    .init_cnt_i(init_cnt_i),
    .tap_i     (tap_i),
    .h_len_o   (h_len),
    .l_len_o   (l_len),
    .d_len_o   (d_len)
  );

  postscale_div_seq #(
    .LEN_W(LEN_W),
    .DLY_W(DLY_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .h_len_i(h_len),
    .l_len_i(l_len),
    .d_len_i(d_len),
    .hi_o   (hi)
  );

  postscale_div_out u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .mode_i(div_mode_e'(mode_i)),
    .hi_i  (hi),
    .clk_o (clk_o)
  );

endmodule

// File: tb/postscale_div_tb.sv
`timescale 1ns/1ps
module postscale_div_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic [8:0] high_cnt_i = 9'd1;
  logic [8:0] low_cnt_i = 9'd1;
  logic [8:0] init_cnt_i = 9'd1;
  logic [2:0] tap_i = 3'd0;
  logic       clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  postscale_div u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode_i),
    .high_cnt_i(high_cnt_i),
    .low_cnt_i (low_cnt_i),
    .init_cnt_i(init_cnt_i),
    .tap_i     (tap_i),
    .clk_o     (clk_o)
  );

  task automatic chk(input string req, input int cyc, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  function automatic int dec(input logic [8:0] f);
    return (f == 9'd0) ? 512 : int'(f);
  endfunction

  function automatic logic pat(input int kind, input int j);
    case (kind)
      1:       return ((j / 7) % 2) == 0;
      2:       return ((j / 5) % 3) != 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_case(input string req, input logic [1:0] md, input logic [8:0] h,
                          input logic [8:0] l, input logic [8:0] ini, input logic [2:0] tp,
                          input int kind, input int ncyc);
    int hh, ll, dd, per, p;
    logic en_per, cur, prev, en_cap, expv;
    bit divmode, oddmode;
    @(negedge clk_i); #1;
    rst_ni = 1'b0;
    mode_i = md; high_cnt_i = h; low_cnt_i = l; init_cnt_i = ini; tap_i = tp;
    en_i = pat(kind, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); #2; chk("R1", -k, clk_o, 1'b0);
      @(negedge clk_i); #2; chk("R1", -k, clk_o, 1'b0);
    end
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    hh = dec(h); ll = dec(l); dd = dec(ini) + int'(tp); per = hh + ll;
    divmode = (md == 2'b01) || (md == 2'b10);
    oddmode = (md == 2'b10);
    en_per = 1'b0; prev = 1'b0; en_cap = 1'b0;
    for (int j = 1; j <= ncyc; j++) begin
      @(posedge clk_i); #2;
      cur = 1'b0;
      if (j >= dd) begin
        p = (j - dd) % per;
        if (p == 0) en_per = en_i;
        cur = (p < hh) && en_per;
      end
      if (!divmode)     expv = en_cap;
      else if (oddmode) expv = cur | prev;
      else              expv = cur;
      chk(req, j, clk_o, expv);
      #2; en_i = pat(kind, j);
      @(negedge clk_i); #2;
      chk(req, j, clk_o, divmode ? cur : 1'b0);
      en_cap = en_i;
      prev = cur;
    end
  endtask

  initial begin
    // R1: reset state
    #12; chk("R1", 0, clk_o, 1'b0);
    // R4: even mode, uneven phases
    run_case("R4", 2'b01, 9'd3, 9'd2, 9'd2, 3'd0, 0, 60);
    // R3: start-up delay with a longer initial count
    run_case("R3", 2'b01, 9'd2, 9'd2, 9'd9, 3'd0, 0, 40);
    // R9: tap added to the delay
    run_case("R9", 2'b01, 9'd1, 9'd1, 9'd1, 3'd7, 0, 30);
    run_case("R9", 2'b10, 9'd2, 9'd3, 9'd3, 3'd2, 0, 50);
    // R5: odd mode, half-cycle stretch
    run_case("R5", 2'b10, 9'd1, 9'd2, 9'd1, 3'd0, 0, 40);
    run_case("R5", 2'b10, 9'd1, 9'd1, 9'd2, 3'd1, 0, 30);
    // R7: enable toggles inside phases
    run_case("R7", 2'b01, 9'd4, 9'd3, 9'd1, 3'd0, 1, 120);
    run_case("R7", 2'b10, 9'd3, 9'd2, 9'd2, 3'd3, 2, 120);
    // R8: gated periods keep the grid
    run_case("R8", 2'b01, 9'd2, 9'd5, 9'd3, 3'd0, 2, 150);
    // R6: bypass, both encodings
    run_case("R6", 2'b00, 9'd3, 9'd3, 9'd1, 3'd0, 1, 60);
    run_case("R6", 2'b11, 9'd3, 9'd3, 9'd1, 3'd0, 2, 60);
    // R2: zero field selects 512
    run_case("R2", 2'b01, 9'd0, 9'd1, 9'd2, 3'd0, 0, 1100);
    run_case("R2", 2'b01, 9'd1, 9'd1, 9'd0, 3'd5, 0, 540);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule